// File: doc/BRIEF.md
# Active-Mode Transfer Sequencer

This block paces pass-through transfers toward add-on logic that issues no strobes of its own. When an active-low attention input shows that a transfer is pending, the sequencer starts on its own. It can first run a one-cycle address phase, driving the transfer address on the data bus under an address strobe. It then holds back each data phase for a programmed number of wait states. An active-low wait input from the add-on stalls the machine at any time: a cycle that follows a low wait sample is idle and is never counted as a wait state.

Each data phase is a one-cycle strobe. If attention is still low at the end of a data phase, another phase follows. Otherwise a one-cycle done pulse marks the end of the transfer. With the programmed count at zero and wait driven low only when needed, stalling is purely on demand.

Top module: `ptx_active_seq`

## Requirements
- R1: While reset is low, and right after it, `adr_stb_n` is 1 and `dq_oe`, `dq_out`, `data_stb` and `done` are 0.
- R2: While idle, a rising edge with `attn_n` low and `wait_n` high starts a transfer. If `addr_en` is 1 at that edge, the next cycle alone has `adr_stb_n` low and `dq_oe` high, with `dq_out` equal to `xfer_addr` as sampled at the start edge.
- R3: If `addr_en` is 0 at the start edge, no address cycle occurs: `adr_stb_n` stays 1 and `dq_oe` stays 0 for the whole transfer.
- R4: A boundary cycle is the start cycle when there is no address phase, the address cycle, or the previous data cycle. Counting from the edge that ends the boundary cycle, the data cycle (`data_stb` high for one cycle) comes right after the (W+1)-th edge at which `wait_n` is high, where W is the latched count. So W counted wait states precede each data phase, and the address cycle is not one of them.
- R5: An edge at which `wait_n` is low does not advance the count. The following cycle is idle and is not counted.
- R6: While `wait_n` is low, a pending attention does not start a transfer. No address or data strobe appears until an edge sees `wait_n` high.
- R7: At the end of a data cycle, `attn_n` low makes another data phase follow. `attn_n` high instead raises `done` for exactly the next cycle and returns the block to idle, ready to start again in that same cycle.
- R8: `wait_cfg` (2-bit count, 0 to 3) and `addr_en` are sampled only at the start edge. Changing them during a transfer does not change its timing.
- R9: With W equal to 0, `wait_n` held high and `attn_n` held low, data cycles come back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| attn_n | input | 1 | Transfer pending, active low |
| wait_n | input | 1 | Add-on stall request, active low |
| addr_en | input | 1 | Run an address phase at transfer start |
| wait_cfg | input | WCW | Programmed wait states per data phase |
| xfer_addr | input | AW | Address of the pending transfer |
| adr_stb_n | output | 1 | Address phase strobe, active low |
| dq_out | output | AW | Address driven during the address phase, zero otherwise |
| dq_oe | output | 1 | Data bus drive enable |
| data_stb | output | 1 | One-cycle data phase strobe |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
Two events can land in the same cycle. A low wait sample can hit the edge that ends a data cycle, so the next beat's count starts with an idle cycle. Separately, the done pulse can share its cycle with the sampling edge of a new start. The bench sweeps every wait count, with and without the address phase, against stall patterns whose low samples fall on boundary, counting and data edges alike, and it chains transfers by pulling attention low again in the done cycle. A cycle-level prediction, built from the edge-counting rule of R4, is compared with every output on every cycle.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_ADDR = 2'd1,
    S_WAIT = 2'd2,
    S_DATA = 2'd3
  } ptx_state_e;
endpackage

// File: rtl/ptx_wait_ctr.sv
module ptx_wait_ctr #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          zero
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = load_val;
    else if (dec) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load || dec) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/ptx_addr_hold.sv
module ptx_addr_hold #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [AW-1:0] addr_in,
  input  logic          drive,
  output logic [AW-1:0] dq_out,
  output logic          dq_oe
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   addr_q <= '0;
    else if (cap) addr_q <= addr_in;
  end

  assign dq_oe  = drive;
  assign dq_out = drive ? addr_q : '0;
endmodule

// File: rtl/ptx_active_seq.sv
module ptx_active_seq #(
  parameter int AW  = 32,
  parameter int WCW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           attn_n,
  input  logic           wait_n,
  input  logic           addr_en,
  input  logic [WCW-1:0] wait_cfg,
  input  logic [AW-1:0]  xfer_addr,
  output logic           adr_stb_n,
  output logic [AW-1:0]  dq_out,
  output logic           dq_oe,
  output logic           data_stb,
  output logic           done
);
  import ptx_pkg::*;

  ptx_state_e     state_q, state_d;
  ptx_state_e     bnd_state;
  logic [WCW-1:0] wcfg_q;
  logic [WCW-1:0] wsel;
  logic [WCW-1:0] bnd_val, ld_val;
  logic           bnd_ld, ld, dec, cap, cnt_zero;
  logic           done_q, done_d;

  // count value in force: live input while idle, latched copy afterwards
  assign wsel = (state_q == S_IDLE) ? wait_cfg : wcfg_q;

  // step taken at the end of a boundary cycle
  always_comb begin
    bnd_state = S_WAIT;
    bnd_ld    = 1'b1;
    bnd_val   = wsel;
    if (wait_n) begin
      if (wsel == '0) begin
        bnd_state = S_DATA;
        bnd_ld    = 1'b0;
      end else begin
        bnd_val = wsel - WCW'(1);
      end
    end
  end

  always_comb begin
    state_d = state_q;
    ld      = 1'b0;
    ld_val  = bnd_val;
    dec     = 1'b0;
    cap     = 1'b0;
    done_d  = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (!attn_n && wait_n) begin
          cap = 1'b1;
          if (addr_en) begin
            state_d = S_ADDR;
          end else begin
            state_d = bnd_state;
            ld      = bnd_ld;
          end
        end
      end
      S_ADDR: begin
        state_d = bnd_state;
        ld      = bnd_ld;
      end
      S_WAIT: begin
        if (wait_n) begin
          if (cnt_zero) state_d = S_DATA;
          else          dec     = 1'b1;
        end
      end
      S_DATA: begin
        if (!attn_n) begin
          state_d = bnd_state;
          ld      = bnd_ld;
        end else begin
          state_d = S_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   wcfg_q <= '0;
    else if (cap) wcfg_q <= wait_cfg;
  end

  ptx_wait_ctr #(.CW(WCW)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld),
    .load_val (ld_val),
    .dec      (dec),
    .zero     (cnt_zero)
  );

  ptx_addr_hold #(.AW(AW)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap     (cap),
    .addr_in (xfer_addr),
    .drive   (state_q == S_ADDR),
    .dq_out  (dq_out),
    .dq_oe   (dq_oe)
  );

  assign adr_stb_n = (state_q != S_ADDR);
  assign data_stb  = (state_q == S_DATA);
  assign done      = done_q;
endmodule

// File: rtl/ptx_seq_chk.sv
module ptx_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          attn_n,
  input logic          wait_n,
  input logic          adr_stb_n,
  input logic [AW-1:0] dq_out,
  input logic          dq_oe,
  input logic          data_stb,
  input logic          done
);
  // R2: the address phase lasts a single cycle
  a_r2_addr_single: assert property (@(posedge clk) disable iff (!rst_n)
    !adr_stb_n |=> adr_stb_n);

  // R2: the bus is driven only while the address strobe is low
  a_r2_oe_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !adr_stb_n);

  // R3: an undriven bus carries zero
  a_r3_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq_out == '0));

  // R6: an address phase begins only after attention with wait high
  a_r6_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adr_stb_n) |-> $past(!attn_n && wait_n));

  // R5: back-to-back data cycles need wait high at the edge between them
  a_r5_no_stall_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (data_stb && $past(data_stb)) |-> $past(wait_n));

  // R7: done is one cycle wide and follows a data cycle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_done_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(data_stb && attn_n));

  // R4: strobes never overlap
  a_r4_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_stb && !adr_stb_n));
endmodule

bind ptx_active_seq ptx_seq_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .attn_n    (attn_n),
  .wait_n    (wait_n),
  .adr_stb_n (adr_stb_n),
  .dq_out    (dq_out),
  .dq_oe     (dq_oe),
  .data_stb  (data_stb),
  .done      (done)
);

// File: tb/sim_ptx_active_seq.sv
`timescale 1ns/1ps
module sim_ptx_active_seq;
  localparam int AW  = 32;
  localparam int WCW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          attn_n, wait_n, addr_en;
  logic [WCW-1:0] wait_cfg;
  logic [AW-1:0] xfer_addr;
  logic          adr_stb_n, dq_oe, data_stb, done;
  logic [AW-1:0] dq_out;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int mode  = 0;
  bit mon_on = 1'b0;

  always #2 clk = ~clk;

  ptx_active_seq #(.AW(AW), .WCW(WCW)) u0 (
    .clk(clk), .rst_n(rst_n), .attn_n(attn_n), .wait_n(wait_n),
    .addr_en(addr_en), .wait_cfg(wait_cfg), .xfer_addr(xfer_addr),
    .adr_stb_n(adr_stb_n), .dq_out(dq_out), .dq_oe(dq_oe),
    .data_stb(data_stb), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // prediction: 0 idle, 1 address, 2 counting, 3 data
  int          m_ph, m_need, m_w;
  logic [AW-1:0] m_addr;
  bit          m_done;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_need = 0; m_w = 0; m_addr = '0; m_done = 0;
    end else begin
      cyc++;
      m_done = 0;
      case (m_ph)
        0: if (!attn_n && wait_n) begin
             m_w = int'(wait_cfg);
             m_addr = xfer_addr;
             if (addr_en) m_ph = 1;
             else begin
               m_need = m_w;
               m_ph = (m_need == 0) ? 3 : 2;
             end
           end
        1: begin
             m_need = m_w + 1 - (wait_n ? 1 : 0);
             m_ph = (m_need == 0) ? 3 : 2;
           end
        2: begin
             if (wait_n) m_need--;
             if (m_need == 0) m_ph = 3;
           end
        default: begin
             if (!attn_n) begin
               m_need = m_w + 1 - (wait_n ? 1 : 0);
               m_ph = (m_need == 0) ? 3 : 2;
             end else begin
               m_ph = 0; m_done = 1;
             end
           end
      endcase
    end
  end

  always @(negedge clk) begin
    if (mon_on) begin
      chk(adr_stb_n == (m_ph != 1), addr_en_tag(), "adr_stb_n", adr_stb_n, m_ph != 1);
      chk(dq_oe == (m_ph == 1), "R2", "dq_oe", dq_oe, m_ph == 1);
      chk(dq_out == ((m_ph == 1) ? m_addr : '0), "R2", "dq_out", dq_out,
          (m_ph == 1) ? m_addr : '0);
      chk(data_stb == (m_ph == 3), (mode != 0) ? "R5" : "R4", "data_stb", data_stb, m_ph == 3);
      chk(done == m_done, "R7", "done", done, m_done);
    end
  end

  function automatic string addr_en_tag();
    return (m_ph == 1) ? "R2" : "R3";
  endfunction

  function automatic logic pat(input int md);
    if (md == 1) return logic'(cyc % 2);
    if (md == 2) return logic'((cyc % 3) != 0);
    return 1'b1;
  endfunction

  task automatic run_xfer(input int w, input bit aen, input int beats,
                          input int md, input bit chain);
    int seen = 0, t = 0, first = -1, last = -1;
    mode      = md;
    wait_cfg  = WCW'(w);
    addr_en   = aen;
    xfer_addr = 32'hA500_0000 ^ AW'((w << 12) | (beats << 8) | (md << 4) | int'(aen));
    attn_n    = 1'b0;
    wait_n    = pat(md);
    while (seen < beats && t < 300) begin
      @(negedge clk);
      t++;
      // R8: scramble configuration once the transfer is under way
      wait_cfg  = ~WCW'(w);
      addr_en   = ~aen;
      xfer_addr = ~xfer_addr;
      if (data_stb) begin
        seen++;
        if (first < 0) first = t;
        last = t;
        if (seen == beats) attn_n = 1'b1;
      end
      wait_n = pat(md);
    end
    chk(seen == beats, "R7", "data phases", seen, beats);
    if (md == 0) begin
      chk(first == int'(aen) + w + 1, "R8", "first data cycle", first, int'(aen) + w + 1);
      chk(last - first == (beats - 1) * (w + 1), (w == 0) ? "R9" : "R4",
          "beat spacing", last - first, (beats - 1) * (w + 1));
    end
    @(negedge clk);
    chk(done == 1'b1, "R7", "done after last beat", done, 1);
    if (chain) begin
      attn_n = 1'b0;
      wait_n = 1'b1;
    end else begin
      attn_n = 1'b1;
      wait_n = 1'b1;
      repeat (2) @(negedge clk);
    end
  endtask

  initial begin
    rst_n = 1'b0; attn_n = 1'b1; wait_n = 1'b1; addr_en = 1'b0;
    wait_cfg = '0; xfer_addr = '0;
    repeat (3) @(negedge clk);
    chk(adr_stb_n && !dq_oe && dq_out == '0 && !data_stb && !done, "R1",
        "reset outputs", {adr_stb_n, dq_oe, data_stb, done}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(adr_stb_n && !dq_oe && !data_stb && !done, "R1", "after release",
        {adr_stb_n, dq_oe, data_stb, done}, 4'b1000);
    mon_on = 1'b1;

    // R6: attention held while wait is low must not start
    addr_en = 1'b1; wait_cfg = 2'd1; attn_n = 1'b0; wait_n = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk(adr_stb_n && !data_stb, "R6", "no start under wait", {adr_stb_n, data_stb}, 2'b10);
    end
    attn_n = 1'b1; wait_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int md = 0; md < 3; md++)
      for (int w = 0; w < 4; w++)
        for (int a = 0; a < 2; a++)
          for (int b = 1; b < 4; b++)
            run_xfer(w, bit'(a), b, md, 1'b0);

    // R7: chained transfers restart in the done cycle
    run_xfer(0, 1'b0, 2, 0, 1'b1);
    run_xfer(2, 1'b1, 1, 0, 1'b1);
    run_xfer(1, 1'b0, 3, 0, 1'b0);

    mon_on = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule